// File: doc/BRIEF.md
# Dual 16-bit Multiply-Accumulate Unit

Two multiply-accumulate lanes run side by side. On every clock with `valid_i` high, each lane takes a 16-bit operand from either the upper or the lower half of each of two shared 32-bit input words. It multiplies the two operands and then does one of four things with the product: loads it into the lane's 40-bit accumulator, adds it, subtracts it, or clears the accumulator. The eight bits above the 32-bit product range give headroom for long sums before overflow.

The format flags are shared by both lanes and are sampled with each operation. They choose signed or unsigned operands, fractional or integer products, and saturating or wrapping accumulation. Each lane keeps a sticky overflow flag. The 16-bit and 32-bit results are formed from the accumulator without a register. They follow the current rounding, saturation and signedness flags, so one accumulator can be read back in several forms.

Top module: `dual_mac`

## Requirements
- R1: While `rst_ni` is low, and after it is released with no operation issued, every accumulator is zero, `ovf_o` is zero and every extracted result is zero.
- R2: Lane k takes its A operand from `a_i[31:16]` when `hsel_a_i[k]`=1 and from `a_i[15:0]` otherwise, and takes its B operand from `b_i` in the same way using `hsel_b_i[k]`. Its 2-bit operation is `op_i[2k+1:2k]`, with 0 = load, 1 = add, 2 = subtract and 3 = clear. With `signed_i`=1 and `frac_i`=0, a load places the sign-extended 32-bit product in the accumulator at the rising edge where `valid_i` is high.
- R3: With `signed_i`=0, the operands and the product are unsigned and the product is zero-extended to 40 bits.
- R4: With `frac_i`=1, the product is shifted left by one bit. With `signed_i`=1 and both operands 0x8000, the product is 0x007FFFFFFF instead.
- R5: Add and subtract combine the product with the accumulator in the selected signedness.
- R6: Operation 3 sets the accumulator to zero and leaves the overflow flag unchanged. `clr_i[k]` zeroes accumulator k and clears `ovf_o[k]` at the next edge, whatever the state of `valid_i`.
- R7: In signed mode, an add or subtract whose result falls outside the 40-bit signed range sets `ovf_o[k]`. The flag then stays set until `clr_i[k]`. With `sat_i`=0 the accumulator wraps, and with `sat_i`=1 it clamps to 0x7FFFFFFFFF or 0x8000000000.
- R8: In unsigned mode, a carry out of an add or a borrow out of a subtract sets `ovf_o[k]`. With `sat_i`=1 the accumulator clamps to 0xFFFFFFFFFF after an add and to 0 after a subtract. With `sat_i`=0 it wraps.
- R9: `res16_o[16k+15:16k]` is bits 31:16 of the accumulator. When `rnd_i`=1, 0x8000 is added to the accumulator before those bits are taken.
- R10: With `sat_i`=1, a 16-bit result that does not fit clamps. In signed mode it clamps to 0x7FFF or 0x8000, and in unsigned mode to 0xFFFF. With `sat_i`=0 the bits wrap.
- R11: `res32_o[32k+31:32k]` is bits 31:0 of the accumulator. With `sat_i`=1 it clamps to 0x7FFFFFFF or 0x80000000 in signed mode, and to 0xFFFFFFFF in unsigned mode.
- R12: With `valid_i` low and `clr_i[k]` low, accumulator k and `ovf_o[k]` hold their values.
- R13: The two lanes are independent. Each uses its own operation and half selects, and each keeps its own accumulator and flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Issue an operation on both lanes |
| a_i | input | 32 | Packed A operand word |
| b_i | input | 32 | Packed B operand word |
| hsel_a_i | input | 2 | Per lane: 1 selects the upper half of A |
| hsel_b_i | input | 2 | Per lane: 1 selects the upper half of B |
| op_i | input | 4 | Per-lane operation, 2 bits each |
| signed_i | input | 1 | 1 = signed operands and accumulation |
| frac_i | input | 1 | 1 = fractional product (left shift by one) |
| rnd_i | input | 1 | Round the 16-bit result |
| sat_i | input | 1 | Saturate the accumulation and the results |
| clr_i | input | 2 | Per-lane accumulator and flag clear |
| acc_o | output | 80 | Accumulators; lane k at bits 40k+39:40k |
| res16_o | output | 32 | 16-bit results; lane k at bits 16k+15:16k |
| res32_o | output | 64 | 32-bit results; lane k at bits 32k+31:32k |
| ovf_o | output | 2 | Sticky overflow flag per lane |

## Verification
The accumulator and the overflow flag change at the first rising edge that samples `valid_i` or `clr_i`. The extracted results are combinational from the accumulator and the current flags, so they are valid in the same cycle as the accumulator. The bench drives inputs on the falling edge and checks the accumulator one falling edge later, once exactly one rising edge has passed. It checks the 16-bit and 32-bit results a quarter period after changing the rounding, saturation or signedness flags, with no edge in between. The long overflow runs check the accumulator at the exact operation count where the 40-bit range is first exceeded, and again one operation later.

// File: rtl/mac_pkg.sv
package mac_pkg;
  typedef enum logic [1:0] {
    OP_LOAD = 2'd0,
    OP_ADD  = 2'd1,
    OP_SUB  = 2'd2,
    OP_CLR  = 2'd3
  } mac_op_e;
endpackage

// File: rtl/mac_mult.sv
module mac_mult #(
  parameter int IW = 16,
  parameter int AW = 40
) (
  input  logic [IW-1:0] a_i,
  input  logic [IW-1:0] b_i,
  input  logic          signed_i,
  input  logic          frac_i,
  output logic [AW-1:0] prod_o
);
  localparam int PW = 2*IW + 2;
  localparam logic [IW-1:0] OPMIN = {1'b1, {(IW-1){1'b0}}};
  localparam logic [AW-1:0] PMAX  = {{(AW-2*IW+1){1'b0}}, {(2*IW-1){1'b1}}};

  logic signed [IW:0]   ax, bx;
  logic signed [PW-1:0] p;
  logic [AW-1:0]        pe;
  logic                 neg_one;

  always_comb begin
    ax = {signed_i & a_i[IW-1], a_i};
    bx = {signed_i & b_i[IW-1], b_i};
    p  = ax * bx;
    pe = {{(AW-PW){p[PW-1]}}, p};
    // -1 x -1 in signed fractional would give +1.0, which is not representable
    neg_one = signed_i & frac_i & (a_i == OPMIN) & (b_i == OPMIN);
    if (neg_one)     prod_o = PMAX;
    else if (frac_i) prod_o = pe << 1;
    else             prod_o = pe;
  end
endmodule

// File: rtl/mac_accum.sv
module mac_accum
  import mac_pkg::*;
#(
  parameter int AW = 40
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          valid_i,
  input  logic          clr_i,
  input  mac_op_e       op_i,
  input  logic          signed_i,
  input  logic          sat_i,
  input  logic [AW-1:0] prod_i,
  output logic [AW-1:0] acc_o,
  output logic          ovf_o
);
  localparam logic [AW-1:0] SMAX = {1'b0, {(AW-1){1'b1}}};
  localparam logic [AW-1:0] SMIN = {1'b1, {(AW-1){1'b0}}};
  localparam logic [AW-1:0] UMAX = {AW{1'b1}};

  logic [AW:0]   a_x, p_x, sum;
  logic          ov, arith;
  logic [AW-1:0] sat_val, nxt;

  always_comb begin
    a_x   = {signed_i & acc_o[AW-1], acc_o};
    p_x   = {signed_i & prod_i[AW-1], prod_i};
    sum   = (op_i == OP_SUB) ? (a_x - p_x) : (a_x + p_x);
    arith = (op_i == OP_ADD) || (op_i == OP_SUB);
    ov    = arith & (signed_i ? (sum[AW] ^ sum[AW-1]) : sum[AW]);
    if (signed_i)            sat_val = sum[AW] ? SMIN : SMAX;
    else if (op_i == OP_SUB) sat_val = '0;
    else                     sat_val = UMAX;
    unique case (op_i)
      OP_LOAD: nxt = prod_i;
      OP_CLR:  nxt = '0;
      default: nxt = (ov && sat_i) ? sat_val : sum[AW-1:0];
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_o <= '0;
      ovf_o <= 1'b0;
    end else if (clr_i) begin
      acc_o <= '0;
      ovf_o <= 1'b0;
    end else if (valid_i) begin
      acc_o <= nxt;
      ovf_o <= ovf_o | ov;
    end
  end
endmodule

// File: rtl/mac_extract.sv
module mac_extract #(
  parameter int IW = 16,
  parameter int AW = 40
) (
  input  logic [AW-1:0]   acc_i,
  input  logic            signed_i,
  input  logic            rnd_i,
  input  logic            sat_i,
  output logic [IW-1:0]   res16_o,
  output logic [2*IW-1:0] res32_o
);
  localparam int HW = AW - IW + 1;
  localparam int WW = 2*IW;

  logic [HW-1:0] hi;
  logic [HW-1:IW-1] hs;
  logic fit16, fit32;

  always_comb begin
    // adding half an LSB and truncating equals a carry-in of bit IW-1
    hi = {signed_i & acc_i[AW-1], acc_i[AW-1:IW]}
         + {{(HW-1){1'b0}}, rnd_i & acc_i[IW-1]};
    hs = hi[HW-1:IW-1];
    if (signed_i) fit16 = (&hs) | ~(|hs);
    else          fit16 = ~(|hi[HW-1:IW]);
    if (sat_i && !fit16)
      res16_o = !signed_i  ? {IW{1'b1}} :
                hi[HW-1]   ? {1'b1, {(IW-1){1'b0}}} : {1'b0, {(IW-1){1'b1}}};
    else
      res16_o = hi[IW-1:0];

    if (signed_i) fit32 = (&acc_i[AW-1:WW-1]) | ~(|acc_i[AW-1:WW-1]);
    else          fit32 = ~(|acc_i[AW-1:WW]);
    if (sat_i && !fit32)
      res32_o = !signed_i    ? {WW{1'b1}} :
                acc_i[AW-1]  ? {1'b1, {(WW-1){1'b0}}} : {1'b0, {(WW-1){1'b1}}};
    else
      res32_o = acc_i[WW-1:0];
  end
endmodule

// File: rtl/dual_mac.sv
module dual_mac
  import mac_pkg::*;
#(
  parameter int LANES = 2,
  parameter int IW    = 16,
  parameter int AW    = 40
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  valid_i,
  input  logic [2*IW-1:0]       a_i,
  input  logic [2*IW-1:0]       b_i,
  input  logic [LANES-1:0]      hsel_a_i,
  input  logic [LANES-1:0]      hsel_b_i,
  input  logic [2*LANES-1:0]    op_i,
  input  logic                  signed_i,
  input  logic                  frac_i,
  input  logic                  rnd_i,
  input  logic                  sat_i,
  input  logic [LANES-1:0]      clr_i,
  output logic [LANES*AW-1:0]   acc_o,
  output logic [LANES*IW-1:0]   res16_o,
  output logic [LANES*2*IW-1:0] res32_o,
  output logic [LANES-1:0]      ovf_o
);
  localparam int WW = 2*IW;

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    logic [IW-1:0] a_h, b_h;
    logic [AW-1:0] prod, acc;
    mac_op_e       op;

    assign a_h = hsel_a_i[k] ? a_i[WW-1:IW] : a_i[IW-1:0];
    assign b_h = hsel_b_i[k] ? b_i[WW-1:IW] : b_i[IW-1:0];
    assign op  = mac_op_e'(op_i[2*k +: 2]);

    mac_mult #(.IW(IW), .AW(AW)) u_mult (
      .a_i(a_h), .b_i(b_h), .signed_i(signed_i), .frac_i(frac_i), .prod_o(prod)
    );

    mac_accum #(.AW(AW)) u_acc (
      .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .clr_i(clr_i[k]),
      .op_i(op), .signed_i(signed_i), .sat_i(sat_i), .prod_i(prod),
      .acc_o(acc), .ovf_o(ovf_o[k])
    );

    mac_extract #(.IW(IW), .AW(AW)) u_ext (
      .acc_i(acc), .signed_i(signed_i), .rnd_i(rnd_i), .sat_i(sat_i),
      .res16_o(res16_o[k*IW +: IW]), .res32_o(res32_o[k*WW +: WW])
    );

    assign acc_o[k*AW +: AW] = acc;
  end
endmodule

// File: rtl/dual_mac_chk.sv
module dual_mac_chk
  import mac_pkg::*;
#(
  parameter int LANES = 2,
  parameter int IW    = 16,
  parameter int AW    = 40
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                valid_i,
  input logic [2*LANES-1:0]  op_i,
  input logic                signed_i,
  input logic                rnd_i,
  input logic                sat_i,
  input logic [LANES-1:0]    clr_i,
  input logic [LANES*AW-1:0] acc_o,
  input logic [LANES*IW-1:0] res16_o,
  input logic [LANES-1:0]    ovf_o
);
  for (genvar k = 0; k < LANES; k++) begin : g_chk
    AST_CLR_EMPTIES: assert property (@(posedge clk_i) disable iff (!rst_ni)
      clr_i[k] |=> (acc_o[k*AW +: AW] == '0) && !ovf_o[k]); // R6

    AST_OP_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (valid_i && !clr_i[k] && op_i[2*k +: 2] == OP_CLR) |=> (acc_o[k*AW +: AW] == '0)); // R6

    AST_IDLE_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!valid_i && !clr_i[k]) |=> ($stable(acc_o[k*AW +: AW]) && $stable(ovf_o[k]))); // R12

    AST_OVF_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ovf_o[k] && !clr_i[k]) |=> ovf_o[k]); // R7

    AST_RES16_SIGN: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (sat_i && signed_i && !rnd_i) |-> (res16_o[k*IW + IW-1] == acc_o[k*AW + AW-1])); // R10
  end
endmodule

bind dual_mac dual_mac_chk #(.LANES(LANES), .IW(IW), .AW(AW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .op_i(op_i),
  .signed_i(signed_i), .rnd_i(rnd_i), .sat_i(sat_i), .clr_i(clr_i),
  .acc_o(acc_o), .res16_o(res16_o), .ovf_o(ovf_o)
);

// File: tb/dual_mac_tb_top.sv
module dual_mac_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 8;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [31:0] a_i = '0, b_i = '0;
  logic [1:0]  hsel_a_i = '0, hsel_b_i = '0, clr_i = '0;
  logic [3:0]  op_i = '0;
  logic        signed_i = 1'b1, frac_i = 1'b0, rnd_i = 1'b0, sat_i = 1'b0;
  logic [79:0] acc_o;
  logic [31:0] res16_o;
  logic [63:0] res32_o;
  logic [1:0]  ovf_o;

  int n_run = 0, n_fail = 0;
  logic done = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  dual_mac dut_i (
    .clk_i, .rst_ni, .valid_i, .a_i, .b_i, .hsel_a_i, .hsel_b_i, .op_i,
    .signed_i, .frac_i, .rnd_i, .sat_i, .clr_i, .acc_o, .res16_o, .res32_o, .ovf_o
  );

  typedef struct packed {
    logic [31:0] a, b;
    logic [1:0]  hsa, hsb;
    logic [3:0]  op;
    logic        sgn, frc;
    logic [39:0] e0, e1;
  } vec_t;

  // op nibble = {lane1 op, lane0 op}
  localparam vec_t VEC [NVEC] = '{
    '{32'h0003_FFFE, 32'h0005_0007, 2'b01, 2'b00, 4'b0000, 1'b1, 1'b0, 40'h00_0000_0015, 40'hFF_FFFF_FFF2}, // R2
    '{32'h0003_FFFE, 32'h0005_0007, 2'b10, 2'b11, 4'b0101, 1'b1, 1'b0, 40'h00_0000_000B, 40'h00_0000_0001}, // R5
    '{32'h1234_0010, 32'h0100_0002, 2'b00, 2'b00, 4'b0110, 1'b1, 1'b0, 40'hFF_FFFF_FFEB, 40'h00_0000_0021}, // R5 R13
    '{32'hFFFF_8000, 32'hFFFF_0002, 2'b01, 2'b01, 4'b0000, 1'b0, 1'b0, 40'h00_FFFE_0001, 40'h00_0001_0000}, // R3
    '{32'h4000_8000, 32'h2000_8000, 2'b01, 2'b01, 4'b0000, 1'b1, 1'b1, 40'h00_1000_0000, 40'h00_7FFF_FFFF}, // R4
    '{32'h4000_8000, 32'h4000_8000, 2'b01, 2'b01, 4'b0101, 1'b1, 1'b1, 40'h00_3000_0000, 40'h00_FFFF_FFFE}, // R4 R5
    '{32'h0000_FFFF, 32'h0000_FFFF, 2'b00, 2'b00, 4'b0011, 1'b0, 1'b1, 40'h00_0000_0000, 40'h01_FFFC_0002}, // R6 R13
    '{32'h8000_7FFF, 32'h8000_7FFF, 2'b01, 2'b10, 4'b0000, 1'b1, 1'b0, 40'hFF_C000_8000, 40'hFF_C000_8000}  // R2
  };

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b,
                      input logic [1:0] hsa, input logic [1:0] hsb,
                      input logic sgn, input logic frc, input logic sat);
    op_i = op; a_i = a; b_i = b; hsel_a_i = hsa; hsel_b_i = hsb;
    signed_i = sgn; frac_i = frc; sat_i = sat; valid_i = 1'b1;
    @(posedge clk_i);
    @(negedge clk_i);
    valid_i = 1'b0;
  endtask

  task automatic clear_all();
    clr_i = 2'b11;
    @(posedge clk_i);
    @(negedge clk_i);
    clr_i = 2'b00;
  endtask

  task automatic settle();
    #(CLK_PERIOD/4);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    chk("R1 acc in reset", {48'b0, acc_o[79:64]} | acc_o[63:0], 64'h0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1 acc after reset", {48'b0, acc_o[79:64]} | acc_o[63:0], 64'h0);
    chk("R1 ovf after reset", {62'b0, ovf_o}, 64'h0);
    chk("R1 res16 after reset", {32'b0, res16_o}, 64'h0);
    chk("R1 res32 after reset", res32_o, 64'h0);

    // table: R2 R3 R4 R5 R6 R13
    for (int i = 0; i < NVEC; i++) begin
      step(VEC[i].op, VEC[i].a, VEC[i].b, VEC[i].hsa, VEC[i].hsb, VEC[i].sgn, VEC[i].frc, 1'b0);
      chk($sformatf("R2/R3/R4/R5 vector %0d lane0", i), {24'b0, acc_o[39:0]}, {24'b0, VEC[i].e0});
      chk($sformatf("R13 vector %0d lane1", i), {24'b0, acc_o[79:40]}, {24'b0, VEC[i].e1});
    end

    // R12: valid low, acc holds
    op_i = 4'b0101; a_i = 32'h1234_5678; b_i = 32'h7654_3210;
    @(posedge clk_i); @(negedge clk_i);
    chk("R12 hold lane0", {24'b0, acc_o[39:0]}, 64'h00_FFC0_008000);
    chk("R12 hold lane1", {24'b0, acc_o[79:40]}, 64'h00_FFC0_008000);

    // R7 wrap: lane0 adds 2^30, lane1 subtracts 2^30
    clear_all();
    for (int i = 0; i < 512; i++)
      step(4'b1001, 32'h8000_8000, 32'h8000_8000, 2'b00, 2'b00, 1'b1, 1'b0, 1'b0);
    chk("R7 wrap at limit lane0", {24'b0, acc_o[39:0]}, 64'h80_0000_0000);
    chk("R7 no ovf at exact min lane1", {24'b0, acc_o[79:40]}, 64'h80_0000_0000);
    chk("R7 R13 flags at limit", {62'b0, ovf_o}, 64'h1);
    step(4'b1001, 32'h8000_8000, 32'h8000_8000, 2'b00, 2'b00, 1'b1, 1'b0, 1'b0);
    chk("R7 wrap lane0", {24'b0, acc_o[39:0]}, 64'h80_4000_0000);
    chk("R7 wrap lane1", {24'b0, acc_o[79:40]}, 64'h7F_C000_0000);
    chk("R7 flags set", {62'b0, ovf_o}, 64'h3);
    step(4'b0000, 32'h0001_0001, 32'h0001_0001, 2'b00, 2'b00, 1'b1, 1'b0, 1'b0);
    chk("R7 sticky after load", {62'b0, ovf_o}, 64'h3);
    chk("R6 op load then R2 value", {24'b0, acc_o[39:0]}, 64'h1);
    clear_all();
    chk("R6 clr_i clears flags", {62'b0, ovf_o}, 64'h0);
    chk("R6 clr_i clears acc", acc_o[63:0], 64'h0);

    // R7 saturating
    for (int i = 0; i < 512; i++)
      step(4'b1001, 32'h8000_8000, 32'h8000_8000, 2'b00, 2'b00, 1'b1, 1'b0, 1'b1);
    chk("R7 sat max lane0", {24'b0, acc_o[39:0]}, 64'h7F_FFFF_FFFF);
    chk("R7 exact min lane1", {24'b0, acc_o[79:40]}, 64'h80_0000_0000);
    chk("R7 flags sat", {62'b0, ovf_o}, 64'h1);
    step(4'b1001, 32'h8000_8000, 32'h8000_8000, 2'b00, 2'b00, 1'b1, 1'b0, 1'b1);
    chk("R7 sat stays max lane0", {24'b0, acc_o[39:0]}, 64'h7F_FFFF_FFFF);
    chk("R7 sat min lane1", {24'b0, acc_o[79:40]}, 64'h80_0000_0000);
    chk("R7 flags both", {62'b0, ovf_o}, 64'h3);

    // R8 unsigned: lane0 adds 0xFFFE0001, lane1 subtracts it
    clear_all();
    for (int i = 0; i < 256; i++)
      step(4'b1001, 32'h0000_FFFF, 32'h0000_FFFF, 2'b00, 2'b00, 1'b0, 1'b0, 1'b1);
    chk("R8 below carry lane0", {24'b0, acc_o[39:0]}, 64'hFF_FE00_0100);
    chk("R8 borrow sat zero lane1", {24'b0, acc_o[79:40]}, 64'h0);
    chk("R8 flags before carry", {62'b0, ovf_o}, 64'h2);
    step(4'b1001, 32'h0000_FFFF, 32'h0000_FFFF, 2'b00, 2'b00, 1'b0, 1'b0, 1'b1);
    chk("R8 carry sat lane0", {24'b0, acc_o[39:0]}, 64'hFF_FFFF_FFFF);
    chk("R8 flags after carry", {62'b0, ovf_o}, 64'h3);
    step(4'b1001, 32'h0000_FFFF, 32'h0000_FFFF, 2'b00, 2'b00, 1'b0, 1'b0, 1'b0);
    chk("R8 carry wrap lane0", {24'b0, acc_o[39:0]}, 64'h00_FFFE_0000);
    chk("R8 borrow wrap lane1", {24'b0, acc_o[79:40]}, 64'hFF_0001_FFFF);

    // R9 rounding
    clear_all();
    step(4'b0000, 32'h0006_0005, 32'h4000_3333, 2'b01, 2'b01, 1'b1, 1'b0, 1'b0);
    rnd_i = 1'b0; settle();
    chk("R9 trunc lane0", {48'b0, res16_o[15:0]}, 64'h0001);
    chk("R9 trunc lane1", {48'b0, res16_o[31:16]}, 64'h0000);
    chk("R11 plain res32 lane0", {32'b0, res32_o[31:0]}, 64'h0001_8000);
    rnd_i = 1'b1; settle();
    chk("R9 round lane0", {48'b0, res16_o[15:0]}, 64'h0002);
    chk("R9 round lane1", {48'b0, res16_o[31:16]}, 64'h0001);
    rnd_i = 1'b0;

    // R10 R11 clamps: lane0 = 0xFFFFFFFE, lane1 = -0xFFFFFFFE
    clear_all();
    step(4'b1000, 32'h8000_8000, 32'h8000_8000, 2'b00, 2'b00, 1'b1, 1'b1, 1'b1);
    step(4'b1001, 32'h8000_8000, 32'h8000_8000, 2'b00, 2'b00, 1'b1, 1'b1, 1'b1);
    chk("R4 R5 frac accum lane0", {24'b0, acc_o[39:0]}, 64'h00_FFFF_FFFE);
    chk("R4 R5 frac accum lane1", {24'b0, acc_o[79:40]}, 64'hFF_0000_0002);
    settle();
    chk("R10 signed clamp hi", {48'b0, res16_o[15:0]}, 64'h7FFF);
    chk("R10 signed clamp lo", {48'b0, res16_o[31:16]}, 64'h8000);
    chk("R11 signed clamp hi", {32'b0, res32_o[31:0]}, 64'h7FFF_FFFF);
    chk("R11 signed clamp lo", {32'b0, res32_o[63:32]}, 64'h8000_0000);
    sat_i = 1'b0; settle();
    chk("R10 wrap lane0", {48'b0, res16_o[15:0]}, 64'hFFFF);
    chk("R10 wrap lane1", {48'b0, res16_o[31:16]}, 64'h0000);
    chk("R11 wrap lane0", {32'b0, res32_o[31:0]}, 64'hFFFF_FFFE);
    chk("R11 wrap lane1", {32'b0, res32_o[63:32]}, 64'h0000_0002);
    sat_i = 1'b1; signed_i = 1'b0; settle();
    chk("R10 unsigned fits lane0", {48'b0, res16_o[15:0]}, 64'hFFFF);
    chk("R10 unsigned clamp lane1", {48'b0, res16_o[31:16]}, 64'hFFFF);
    chk("R11 unsigned fits lane0", {32'b0, res32_o[31:0]}, 64'hFFFF_FFFE);
    chk("R11 unsigned clamp lane1", {32'b0, res32_o[63:32]}, 64'hFFFF_FFFF);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule